// File: doc/BRIEF.md
# Two-Processor Mailbox Channel Controller

This block lets two processors signal each other over a set of one-bit channels. Each processor has its own register bank with a command register and an occupied-status register. A processor raises an outgoing channel by writing a one to the upper (transmit) half of its own command register. The flag then appears in its own status register. The peer sees the pending message by reading that status register. After the peer consumes the message, it writes a one to the lower (receive) half of its own command register, and that write releases the channel in the sender's status register.

The block has two independent single-cycle register access ports, so both processors can issue commands in the same cycle. Addresses are absolute: any port may reach either bank. Each processor gets one interrupt line. The line is high while at least one of the peer's outgoing channels is occupied. A read-only configuration word reports how many channels exist.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset every status bit is 0 and both interrupt lines are low.
- R2: A write with bit (16+n) set to the command register of bank p (address p*0x10+0x08) sets status bit n of bank p. The change is visible from the clock edge that ends the write cycle.
- R3: A write with bit n set to the command register of bank p clears status bit n of bank 1-p, with the same timing as R2.
- R4: Command bits written as 0 change nothing. Command bits for channel numbers at or above NUM_CH, in either half, are ignored.
- R5: A read of a command register returns zero.
- R6: A read of address 0x3F0 returns NUM_CH in bits 7:0 and zeros above.
- R7: A read of any address other than the two status registers and 0x3F0 returns zero, and rdata is zero whenever the port's read enable is low. Status of bank p is read at p*0x10+0x0C in bits NUM_CH-1:0.
- R8: irq[p] is high exactly while status of bank 1-p is nonzero.
- R9: If one port sets channel n of bank q while the other port clears the same channel of bank q in the same cycle, the bit ends up set.
- R10: When both ports write command bits in the same cycle, the effects of both writes are applied together.
- R11: A write to a status register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data (same cycle) |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data (same cycle) |
| irq | output | 2 | irq[p]: a peer channel is pending for processor p |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. Status bits and interrupt lines change at the first rising edge after a command write. The bench drives every input just after a falling edge. It compares both read ports 1 ns later, in the same cycle, against a behavioural model. It advances the model only at the rising edge, so the interrupt lines are compared in the cycle after the write that caused them. Directed steps cover each requirement, including a set and a clear that collide in one cycle, and a random phase then mixes commands and reads on both ports.

// File: rtl/mbox_pkg.sv
// Shared types for the two-processor mailbox controller.
// Assumes exactly two processor banks; bank index is a single bit.
package mbox_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CMD  = 2'd1,
        RGN_STAT = 2'd2,
        RGN_CFG  = 2'd3
    } rgn_e;

    typedef struct packed {
        rgn_e rgn;
        logic bank;
    } sel_t;
endpackage

// File: rtl/mbox_port_decode.sv
// Decodes one access port: classifies the address and turns command
// writes into per-bank set and clear masks.
// Assumes NUM_CH <= TX_LSB so the receive and transmit halves do not overlap.
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int STRIDE   = 16,
    parameter int CMD_OFS  = 8,
    parameter int STAT_OFS = 12,
    parameter int CFG_OFS  = 1008,
    parameter int TX_LSB   = 16
) (
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output sel_t                  sel,
    output logic [1:0][NUM_CH-1:0] set_mask,
    output logic [1:0][NUM_CH-1:0] clr_mask
);
    // Address classification against both banks and the config word.
    always_comb begin
        sel = '{rgn: RGN_NONE, bank: 1'b0};
        for (int b = 0; b < 2; b++) begin
            if (addr == ADDR_W'(b * STRIDE + CMD_OFS))
                sel = '{rgn: RGN_CMD, bank: 1'(b)};
            if (addr == ADDR_W'(b * STRIDE + STAT_OFS))
                sel = '{rgn: RGN_STAT, bank: 1'(b)};
        end
        if (addr == ADDR_W'(CFG_OFS))
            sel = '{rgn: RGN_CFG, bank: 1'b0};
    end

    // Command write: upper half sets own bank, lower half clears peer bank.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (wr && sel.rgn == RGN_CMD) begin
            set_mask[sel.bank]  = wdata[TX_LSB +: NUM_CH];
            clr_mask[~sel.bank] = wdata[0 +: NUM_CH];
        end
    end
endmodule

// File: rtl/mbox_status_bank.sv
// Occupied-status register of one processor bank.
// Assumes set and clear masks are already merged across ports; set wins.
module mbox_status_bank #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_in,
    input  logic [NUM_CH-1:0] clr_in,
    output logic [NUM_CH-1:0] stat_q
);
    // Update the occupied flags; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_in) | set_in;
    end
endmodule

// File: rtl/mbox_read_mux.sv
// Same-cycle read data selection for one access port.
// Assumes NUM_CH fits in the 8-bit count field of the config word.
module mbox_read_mux
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input  logic                   rd,
    input  sel_t                   sel,
    input  logic [1:0][NUM_CH-1:0] stat,
    output logic [DATA_W-1:0]      rdata
);
    localparam logic [7:0] CH_CNT = 8'(NUM_CH);

    // Pick status or config; command and unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel.rgn)
                RGN_STAT: rdata = DATA_W'(stat[sel.bank]);
                RGN_CFG:  rdata = DATA_W'(CH_CNT);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_ctrl.sv
// Two-processor mailbox channel controller top level.
// Two absolute-address access ports share two status banks; each
// processor gets an interrupt while any peer channel is occupied.
// Assumes NUM_CH <= 16 and a synchronous active-low reset.
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic [1:0]        irq
);
    localparam int N_PORTS = 2;

    logic [N_PORTS-1:0]                  p_wr;
    logic [N_PORTS-1:0]                  p_rd;
    logic [N_PORTS-1:0][ADDR_W-1:0]      p_addr;
    logic [N_PORTS-1:0][DATA_W-1:0]      p_wdata;
    logic [N_PORTS-1:0][DATA_W-1:0]      p_rdata;
    sel_t [N_PORTS-1:0]                  p_sel;
    logic [N_PORTS-1:0][1:0][NUM_CH-1:0] p_set;
    logic [N_PORTS-1:0][1:0][NUM_CH-1:0] p_clr;
    logic [1:0][NUM_CH-1:0]              set_all;
    logic [1:0][NUM_CH-1:0]              clr_all;
    logic [1:0][NUM_CH-1:0]              stat;

    // Gather the two named ports into indexed arrays.
    assign p_wr    = {b_wr, a_wr};
    assign p_rd    = {b_rd, a_rd};
    assign p_addr  = {b_addr, a_addr};
    assign p_wdata = {b_wdata, a_wdata};
    assign a_rdata = p_rdata[0];
    assign b_rdata = p_rdata[1];

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        mbox_port_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
            .wr       (p_wr[g]),
            .addr     (p_addr[g]),
            .wdata    (p_wdata[g]),
            .sel      (p_sel[g]),
            .set_mask (p_set[g]),
            .clr_mask (p_clr[g])
        );
        mbox_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rmux (
            .rd    (p_rd[g]),
            .sel   (p_sel[g]),
            .stat  (stat),
            .rdata (p_rdata[g])
        );
    end

    // Merge command effects from all ports per bank.
    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            set_all = set_all | p_set[p];
            clr_all = clr_all | p_clr[p];
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        mbox_status_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_in (set_all[b]),
            .clr_in (clr_all[b]),
            .stat_q (stat[b])
        );
        assign irq[b] = |stat[1-b];
    end
endmodule

// File: rtl/mbox_ctrl_chk.sv
// Property checker for mbox_ctrl, bound to every instance.
// Observes the ports and the bank registers only.
module mbox_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   a_wr,
    input logic                   a_rd,
    input logic [ADDR_W-1:0]      a_addr,
    input logic [DATA_W-1:0]      a_wdata,
    input logic [DATA_W-1:0]      a_rdata,
    input logic                   b_wr,
    input logic [ADDR_W-1:0]      b_addr,
    input logic [DATA_W-1:0]      b_wdata,
    input logic [1:0]             irq,
    input logic [1:0][NUM_CH-1:0] stat
);
    logic [NUM_CH-1:0] a_set0, b_set0, a_clr1, b_set1;
    logic              a_mapped;

    // Observed command effects taken straight from the port data.
    always_comb begin
        a_set0 = (a_wr && a_addr == ADDR_W'(8))  ? a_wdata[16 +: NUM_CH] : '0;
        b_set0 = (b_wr && b_addr == ADDR_W'(8))  ? b_wdata[16 +: NUM_CH] : '0;
        a_clr1 = (a_wr && a_addr == ADDR_W'(8))  ? a_wdata[0 +: NUM_CH]  : '0;
        b_set1 = (b_wr && b_addr == ADDR_W'(24)) ? b_wdata[16 +: NUM_CH] : '0;
        a_mapped = (a_addr == ADDR_W'(12)) || (a_addr == ADDR_W'(28)) ||
                   (a_addr == ADDR_W'(1008));
    end

    AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_set0 != '0) |=> ((stat[0] & $past(a_set0)) == $past(a_set0))); // R9

    AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_clr1 & ~b_set1) != '0) |=> ((stat[1] & $past(a_clr1 & ~b_set1)) == '0)); // R3

    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat[0] & ~$past(stat[0]) & ~$past(a_set0 | b_set0)) == '0)); // R4

    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && a_addr == ADDR_W'(8)) |-> (a_rdata == '0)); // R5

    AST_CFG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && a_addr == ADDR_W'(1008)) |-> (a_rdata == DATA_W'(NUM_CH))); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_rd || !a_mapped) |-> (a_rdata == '0)); // R7

    AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && a_addr == ADDR_W'(28)) |-> (irq[0] == (a_rdata != '0))); // R8
endmodule

bind mbox_ctrl mbox_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_wr    (a_wr),
    .a_rd    (a_rd),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_wr    (b_wr),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .irq     (irq),
    .stat    (stat)
);

// File: tb/tb_mbox_ctrl.sv
// Self-checking bench for mbox_ctrl with a behavioural reference model.
module tb_mbox_ctrl;
    localparam int NCH = 8;
    localparam int AW  = 10;
    localparam int DW  = 32;
    localparam logic [NCH-1:0] CHM = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic [1:0]    irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [NCH-1:0] mst [2];

    always #10 clk = ~clk;

    mbox_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .irq(irq)
    );

    function automatic logic [DW-1:0] model_rd(input logic rd, input logic [AW-1:0] ad);
        if (!rd) return '0;
        case (ad)
            10'h00C: return DW'(mst[0]);
            10'h01C: return DW'(mst[1]);
            10'h3F0: return DW'(NCH);
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One bus cycle on both ports, compared against the model.
    task automatic step(input logic aw, input logic ar, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                        input logic bw, input logic br, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                        input string tag);
        logic [NCH-1:0] setm [2];
        logic [NCH-1:0] clrm [2];
        a_wr = aw; a_rd = ar; a_addr = aa; a_wdata = ad;
        b_wr = bw; b_rd = br; b_addr = ba; b_wdata = bd;
        #1;
        check(tag, "a_rdata", a_rdata, model_rd(ar, aa));
        check(tag, "b_rdata", b_rdata, model_rd(br, ba));
        check(tag, "irq", DW'(irq), DW'({|mst[0], |mst[1]}));
        @(posedge clk);
        for (int q = 0; q < 2; q++) begin
            setm[q] = '0;
            clrm[q] = '0;
        end
        for (int q = 0; q < 2; q++) begin
            if (aw && aa == AW'(q * 16 + 8)) begin
                setm[q]   = setm[q]   | (ad[16 +: NCH] & CHM);
                clrm[1-q] = clrm[1-q] | (ad[0 +: NCH] & CHM);
            end
            if (bw && ba == AW'(q * 16 + 8)) begin
                setm[q]   = setm[q]   | (bd[16 +: NCH] & CHM);
                clrm[1-q] = clrm[1-q] | (bd[0 +: NCH] & CHM);
            end
        end
        for (int q = 0; q < 2; q++) mst[q] = (mst[q] & ~clrm[q]) | setm[q];
        @(negedge clk);
    endtask

    task automatic rd2(input string tag);
        step(0, 1, 10'h00C, '0, 0, 1, 10'h01C, '0, tag);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] pool [7];
        pool = '{10'h008, 10'h00C, 10'h018, 10'h01C, 10'h3F0, 10'h004, 10'h3FC};
        mst[0] = '0; mst[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd2("R1");                                          // reset state
        step(1, 0, 10'h008, 32'h0001_0000, 0, 0, '0, '0, "R2"); // P0 raises ch0
        rd2("R2");
        step(1, 0, 10'h018, 32'h0084_0000, 0, 0, '0, '0, "R2"); // P1 raises ch2, ch7
        rd2("R8");
        step(0, 0, '0, '0, 1, 0, 10'h018, 32'h0000_0001, "R3");  // P1 releases P0 ch0
        rd2("R3");
        step(1, 0, 10'h008, 32'h0000_0004, 0, 0, '0, '0, "R3");  // P0 releases P1 ch2
        rd2("R8");
        step(1, 0, 10'h008, 32'h0000_0000, 0, 0, '0, '0, "R4");  // zeros
        step(1, 0, 10'h008, 32'hFF00_FF00, 0, 0, '0, '0, "R4");  // out-of-range bits
        rd2("R4");
        step(0, 1, 10'h008, '0, 0, 1, 10'h018, '0, "R5");
        step(0, 1, 10'h3F0, '0, 0, 1, 10'h3F0, '0, "R6");
        step(0, 1, 10'h004, '0, 0, 1, 10'h3FC, '0, "R7");
        step(0, 0, 10'h00C, '0, 0, 0, 10'h01C, '0, "R7");       // read enable low
        step(1, 0, 10'h008, 32'h0001_0000, 1, 0, 10'h018, 32'h0000_0001, "R9");
        rd2("R9");
        step(1, 0, 10'h018, 32'h0002_0000, 1, 0, 10'h018, 32'h0010_0000, "R10");
        rd2("R10");
        step(1, 0, 10'h01C, 32'hFFFF_FFFF, 1, 0, 10'h00C, 32'h0, "R11");
        rd2("R11");
        step(1, 0, 10'h008, 32'h00FF_00FF, 1, 0, 10'h018, 32'h0000_00FF, "R8");
        rd2("R8");
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom), 1'($urandom), pool[$urandom % 7], $urandom,
                 1'($urandom), 1'($urandom), pool[$urandom % 7], $urandom, "R10");
        end
        rd2("R2");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule